// File: doc/BRIEF.md
# Half-Duplex Transmit/Receive Mode Sequencer

This block decides, on every cycle of the crystal-rate clock, whether a half-duplex modem transmits or receives. A single select line asks for transmit when low and for receive when high. A transmit watchdog protects the shared line. If the transmit request stays asserted too long, the sequencer drops back to receive and stays there. It leaves that locked state only after the select line has been released high for a minimum time and then pulled low again.

Two test inputs change this behaviour. A fast-timeout input replaces the long watchdog limit with a short one. A hold input bypasses the watchdog, so the select line alone chooses the mode. While hold is set and the block is receiving, a test data pin replaces the demodulator as the source for clock recovery. An active-low power input puts the whole block in power-down, with both enables off and all state cleared.

Top module: `txrx_mode_ctl`

## Requirements
- R1: While `pwr_on` is low, from the next rising edge onward `tx_en`, `rx_en` and `cr_sel_test` are 0 and every internal state is cleared, including a watchdog lock. On the first edge with `pwr_on` high the block enters receive.
- R2: `rxtx_sel` passes through two synchronizing flops. A change on it reaches `tx_en`/`rx_en` at the third rising edge after the change is first sampled.
- R3: When powered, `rxtx_sel` = 0 requests transmit (`tx_en`=1, `rx_en`=0) and `rxtx_sel` = 1 selects receive (`tx_en`=0, `rx_en`=1). `tx_en` and `rx_en` are never both 1.
- R4: With `tst_hold`=0 and `tst_fast`=0, an unbroken transmit request keeps `tx_en` high for exactly `TO_LONG` cycles. The block then switches to receive.
- R5: With `tst_fast`=1, the same limit is `TO_SHORT` cycles.
- R6: After a watchdog expiry the block stays in receive while `rxtx_sel` remains 0.
- R7: After an expiry, transmit is entered again only after the synchronized `rxtx_sel` has been 1 for at least `REARM_MIN` consecutive cycles and then returns to 0. A shorter high pulse leaves the block locked in receive.
- R8: The watchdog count restarts at zero for every accepted transmit session.
- R9: While `tst_hold`=1 the watchdog never expires and any lock is cleared, so `rxtx_sel` alone selects transmit or receive. A count that is already beyond the limit when hold is released causes a lock on the next cycle.
- R10: While `tst_hold`=1 and `rx_en`=1, `cr_sel_test`=1 and `cr_din` follows `tst_cr_data`. Otherwise `cr_sel_test`=0 and `cr_din` follows `demod_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| pwr_on | input | 1 | Active-low power-down; 0 clears everything |
| rxtx_sel | input | 1 | Mode select: 0 transmit request, 1 receive |
| tst_hold | input | 1 | Bypass watchdog; route test data to clock recovery |
| tst_fast | input | 1 | Use the short watchdog limit |
| tst_cr_data | input | 1 | Test data for the clock recovery input |
| demod_in | input | 1 | Demodulated data from the receive path |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| cr_sel_test | output | 1 | Clock recovery takes test data |
| cr_din | output | 1 | Data presented to clock recovery |

## Verification
On every cycle the assertions check the following:
- the enables are quiet after power-down;
- transmit and receive are mutually exclusive;
- transmit is entered only when the synchronized request was present;
- a locked, unarmed state never yields transmit;
- hold forbids a lock;
- the watchdog count stays bounded.

Only the bench scenarios can show the exact session lengths for both limits, the boundary at `REARM_MIN` minus one versus `REARM_MIN` high cycles, and the restart of the count between sessions. The same applies to the three-edge latency and to the release of a lock by power-down. The bench uses small limits so that these lengths can be measured.

// File: rtl/txrx_mode_pkg.sv
package txrx_mode_pkg;

    typedef enum logic [1:0] {
        M_OFF  = 2'd0,
        M_RX   = 2'd1,
        M_TX   = 2'd2,
        M_LOCK = 2'd3
    } mode_e;

    // Last count value of a session under the selected limit
    function automatic int unsigned last_count(input logic fast,
                                               input int unsigned lim_long,
                                               input int unsigned lim_short);
        return (fast ? lim_short : lim_long) - 1;
    endfunction

endpackage

// File: rtl/txrx_sync.sv
module txrx_sync #(
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (clr) sh_q <= {STAGES{RST_VAL}};
        else     sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/txrx_wdog.sv
module txrx_wdog
    import txrx_mode_pkg::*;
#(
    parameter int unsigned TO_LONG  = 33_177_600,
    parameter int unsigned TO_SHORT = 16_368,
    localparam int CW = $clog2(TO_LONG + 1)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          run,
    input  logic          fast,
    output logic          expired,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    always_comb last = CW'(last_count(fast, TO_LONG, TO_SHORT));

    always_ff @(posedge clk) begin
        if (clr || !run)                 cnt_q <= '0;
        else if (cnt_q < CW'(TO_LONG))   cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q >= last);
    assign cnt     = cnt_q;
endmodule

// File: rtl/txrx_rearm.sv
module txrx_rearm #(
    parameter int unsigned REARM_MIN = 23,
    localparam int RW = $clog2(REARM_MIN + 1)
) (
    input  logic clk,
    input  logic clr,
    input  logic hi,
    input  logic locked,
    output logic armed
);
    logic [RW-1:0] run_q;
    logic          armed_q;
    logic          full;

    assign full = run_q >= RW'(REARM_MIN);

    always_ff @(posedge clk) begin
        if (clr) begin
            run_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (!hi)       run_q <= '0;
            else if (!full) run_q <= run_q + 1'b1;
            armed_q <= locked ? (armed_q | full) : 1'b0;
        end
    end

    assign armed = armed_q;
endmodule

// File: rtl/txrx_mode_ctl.sv
module txrx_mode_ctl
    import txrx_mode_pkg::*;
#(
    parameter int unsigned TO_LONG   = 33_177_600,
    parameter int unsigned TO_SHORT  = 16_368,
    parameter int unsigned REARM_MIN = 23,
    parameter int          SYNC_STG  = 2,
    localparam int CW = $clog2(TO_LONG + 1)
) (
    input  logic clk,
    input  logic pwr_on,
    input  logic rxtx_sel,
    input  logic tst_hold,
    input  logic tst_fast,
    input  logic tst_cr_data,
    input  logic demod_in,
    output logic tx_en,
    output logic rx_en,
    output logic cr_sel_test,
    output logic cr_din
);
    logic          clr;
    logic          sel_s;
    logic          txreq;
    logic          expired;
    logic          armed;
    logic          in_lock;
    logic [CW-1:0] wd_cnt;
    mode_e         mode_q, mode_d;

    assign clr = ~pwr_on;

    txrx_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .clr(clr), .d(rxtx_sel), .q(sel_s)
    );
    assign txreq = ~sel_s;

    txrx_wdog #(.TO_LONG(TO_LONG), .TO_SHORT(TO_SHORT)) u_wd (
        .clk(clk), .clr(clr), .run(mode_q == M_TX), .fast(tst_fast),
        .expired(expired), .cnt(wd_cnt)
    );

    assign in_lock = (mode_q == M_LOCK);

    txrx_rearm #(.REARM_MIN(REARM_MIN)) u_rearm (
        .clk(clk), .clr(clr), .hi(sel_s), .locked(in_lock), .armed(armed)
    );

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            M_OFF:  mode_d = M_RX;
            M_RX:   mode_d = txreq ? M_TX : M_RX;
            M_TX: begin
                if (!txreq)                    mode_d = M_RX;
                else if (!tst_hold && expired) mode_d = M_LOCK;
            end
            M_LOCK: if (txreq && armed)        mode_d = M_TX;
            default: mode_d = M_OFF;
        endcase
        if (tst_hold && mode_q != M_OFF)
            mode_d = txreq ? M_TX : M_RX;
    end

    always_ff @(posedge clk) begin
        if (clr) mode_q <= M_OFF;
        else     mode_q <= mode_d;
    end

    assign tx_en       = (mode_q == M_TX);
    assign rx_en       = (mode_q == M_RX) || (mode_q == M_LOCK);
    assign cr_sel_test = tst_hold && rx_en;
    assign cr_din      = cr_sel_test ? tst_cr_data : demod_in;
endmodule

// File: rtl/txrx_mode_chk.sv
module txrx_mode_chk #(
    parameter int unsigned TO_LONG = 33_177_600,
    parameter int CW = 25
) (
    input logic          clk,
    input logic          pwr_on,
    input logic          tst_hold,
    input logic          tx_en,
    input logic          rx_en,
    input logic          txreq,
    input logic          in_lock,
    input logic          armed,
    input logic [CW-1:0] wd_cnt
);
    a_r1_off_quiet: assert property (@(posedge clk)
        !pwr_on |=> (!tx_en && !rx_en));

    a_r3_exclusive: assert property (@(posedge clk) disable iff (!pwr_on)
        !(tx_en && rx_en));

    a_r3_tx_needs_req: assert property (@(posedge clk) disable iff (!pwr_on)
        tx_en |-> $past(txreq));

    a_r7_lock_holds: assert property (@(posedge clk) disable iff (!pwr_on)
        $past(in_lock && !armed && !tst_hold) |-> !tx_en);

    a_r9_hold_no_lock: assert property (@(posedge clk) disable iff (!pwr_on)
        $past(tst_hold) |-> !in_lock);

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!pwr_on)
        wd_cnt <= CW'(TO_LONG));
endmodule

bind txrx_mode_ctl txrx_mode_chk #(.TO_LONG(TO_LONG), .CW(CW)) u_chk (
    .clk(clk), .pwr_on(pwr_on), .tst_hold(tst_hold), .tx_en(tx_en),
    .rx_en(rx_en), .txreq(txreq), .in_lock(in_lock), .armed(armed),
    .wd_cnt(wd_cnt)
);

// File: tb/tb_txrx_mode_ctl.sv
`timescale 1ns/1ps
module tb_txrx_mode_ctl;
    localparam int L = 120;
    localparam int S = 30;
    localparam int M = 6;

    logic clk = 1'b0;
    logic pwr_on, rxtx_sel, tst_hold, tst_fast, tst_cr_data, demod_in;
    logic tx_en, rx_en, cr_sel_test, cr_din;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #4 clk = ~clk;

    txrx_mode_ctl #(.TO_LONG(L), .TO_SHORT(S), .REARM_MIN(M)) dut (
        .clk(clk), .pwr_on(pwr_on), .rxtx_sel(rxtx_sel), .tst_hold(tst_hold),
        .tst_fast(tst_fast), .tst_cr_data(tst_cr_data), .demod_in(demod_in),
        .tx_en(tx_en), .rx_en(rx_en), .cr_sel_test(cr_sel_test), .cr_din(cr_din)
    );

    // [9]pwr [8]rxtx [7]hold [6]fast [5]t3 [4]demod | [3]tx [2]rx [1]sel [0]cr
    localparam logic [9:0] VEC [8] = '{
        10'b0_1_0_0_0_1_0_0_0_1,  // R1 powered down
        10'b1_1_0_0_0_1_0_1_0_1,  // R3 receive, R10 demod path
        10'b1_0_0_0_0_1_1_0_0_1,  // R3 transmit
        10'b1_1_1_0_1_0_0_1_1_1,  // R10 test data 1
        10'b1_1_1_0_0_1_0_1_1_0,  // R10 test data 0
        10'b1_0_1_0_0_1_1_0_0_1,  // R9 hold transmit
        10'b1_1_0_1_1_0_0_1_0_0,  // R10 demod path again
        10'b0_1_0_0_1_1_0_0_0_1   // R1 powered down again
    };
    logic [9:0] v;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tx();
        int g = 0;
        while (!tx_en && g < 1000) begin tick(1); g++; end
    endtask

    task automatic count_tx(output int n);
        n = 0;
        while (tx_en && n < 1000) begin n++; tick(1); end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        pwr_on = 0; rxtx_sel = 1; tst_hold = 0; tst_fast = 0;
        tst_cr_data = 0; demod_in = 0;
        tick(3);
        chk("R1 reset tx_en", tx_en, 0);
        chk("R1 reset rx_en", rx_en, 0);

        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            {pwr_on, rxtx_sel, tst_hold, tst_fast, tst_cr_data, demod_in} = v[9:4];
            tick(5);
            chk("R3/R1 vec tx_en", tx_en, v[3]);
            chk("R3/R1 vec rx_en", rx_en, v[2]);
            chk("R10 vec cr_sel_test", cr_sel_test, v[1]);
            chk("R10 vec cr_din", cr_din, v[0]);
        end

        pwr_on = 1; rxtx_sel = 1; tst_hold = 0; tst_fast = 0;
        tick(5);
        rxtx_sel = 0;
        tick(2);
        chk("R2 not yet tx", tx_en, 0);
        tick(1);
        chk("R2 tx on third edge", tx_en, 1);
        count_tx(n);
        chk("R4 long session length", n, L);
        chk("R6 rx after expiry", rx_en, 1);
        tick(20);
        chk("R6 still locked", tx_en, 0);

        rxtx_sel = 1; tick(M - 1); rxtx_sel = 0; tick(10);
        chk("R7 short pulse stays locked", tx_en, 0);
        rxtx_sel = 1; tick(M); rxtx_sel = 0; tick(10);
        chk("R7 full pulse re-arms", tx_en, 1);

        rxtx_sel = 1; tick(6);
        chk("R3 back to receive", rx_en, 1);
        tst_fast = 1; rxtx_sel = 0;
        wait_tx();
        count_tx(n);
        chk("R5 short session length", n, S);

        tst_fast = 0;
        rxtx_sel = 1; tick(M); rxtx_sel = 0;
        wait_tx();
        tick(100);
        chk("R8 still tx at 100", tx_en, 1);
        rxtx_sel = 1; tick(6); rxtx_sel = 0;
        wait_tx();
        count_tx(n);
        chk("R8 restarted session length", n, L);

        tst_hold = 1; tick(3);
        chk("R9 hold clears lock", tx_en, 1);
        tick(300);
        chk("R9 hold no expiry", tx_en, 1);
        tst_hold = 0; tick(3);
        chk("R9 release locks", tx_en, 0);
        chk("R9 release rx", rx_en, 1);

        pwr_on = 0; tick(2);
        chk("R1 power-down tx", tx_en, 0);
        chk("R1 power-down rx", rx_en, 0);
        pwr_on = 1; tick(5);
        chk("R1 lock cleared by power-down", tx_en, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule